// File: doc/BRIEF.md
# PCM Sample Packing Buffer Writer

This block takes 16-bit PCM audio samples, one left/right pair per valid strobe, and packs them into 32-bit little-endian words. Each word is written to the next address of a ring buffer in memory through a simple write port. A start pulse latches the buffer base address, the buffer length (counted in 16-bit samples) and the channel mode. Capture then runs without a break, wrapping back to the base address each time the buffer fills. Each wrap raises a one-cycle end-of-buffer pulse on the same cycle as the buffer's last write.

A stop pulse does not halt capture at once. It is held until the buffer in progress has been completely written. After that final write, a one-cycle stopped pulse reports that the block is idle and that every word has reached memory. Stereo mode stores one left/right pair per word. Mono mode stores only left samples, two to a word.

Top module: `pcm_pack_writer`

## Requirements
- R1: After reset the block is idle: `mem_we`, `buf_end` and `stopped` are low, and samples are not written until a start pulse is accepted.
- R2: In stereo mode (`mono`=0) each accepted sample pair produces one write. The write appears in the cycle after the strobe is sampled, with data {right[15:0] in bits 31:16, left[15:0] in bits 15:0}.
- R3: In mono mode (`mono`=1) only left samples are kept. The earlier sample of each pair goes in bits 15:0 and the later one in bits 31:16, and the word is written in the cycle after the later sample is sampled.
- R4: In mono mode with an odd length, the final sample of the buffer is written on its own, in the cycle after it is sampled, with zero in bits 31:16.
- R5: A buffer of length N samples occupies ceil(N/2) words at byte addresses base, base+4, base+8 and onward, written in order.
- R6: When a buffer completes with no stop pending, `buf_end` is high for exactly the cycle of its last write, and the next write goes to the base address again.
- R7: A stop pulse during capture takes effect only at the end of the current buffer. `stopped` is high for one cycle, in the cycle right after the last write, and no write follows.
- R8: A start pulse while capture is running or stopping is ignored. Base, length and mode stay as latched, and the write sequence carries on unchanged.
- R9: A stop pulse while idle has no effect on the next capture, and sample strobes while idle cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One sample pair is present this cycle |
| smp_left | input | 16 | Left channel PCM sample |
| smp_right | input | 16 | Right channel PCM sample |
| base_addr | input | AW (32) | Buffer byte base address, latched at start |
| max_count | input | CW (16) | Buffer length in 16-bit samples (at least 1), latched at start |
| mono | input | 1 | 1 = mono (left only), 0 = stereo, latched at start |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop request pulse |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW (32) | Write byte address |
| mem_wdata | output | 32 | Write data word |
| stopped | output | 1 | One-cycle pulse once capture and writes have ended |
| buf_end | output | 1 | One-cycle pulse with the last write of each buffer |

## Verification
A write is due one cycle after the strobe that completes its word: each stereo pair completes a word, in mono the second sample of a pair does, and so does a lone final sample. `buf_end` falls on that same cycle, and `stopped` follows one cycle later. The driver applies every stimulus at a falling edge and pushes the word it predicts into a queue. The monitor samples `mem_we` at the next falling edge, pops the prediction and compares address, data and `buf_end`. It also expects `stopped` exactly one falling edge after a word marked as closing a stopped buffer. Any write with an empty queue, and any `stopped` at another time, is reported as a failure.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } run_state_e;
endpackage

// File: rtl/pcm_run_ctrl.sv
module pcm_run_ctrl
  import pcm_pack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic word_fire,
  input  logic word_last,
  output logic run,
  output logic load,
  output logic stopped
);
  run_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       stopped_q;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (start) begin
          state_d = ST_RUN;
          load    = 1'b1;
        end
      end
      ST_RUN: begin
        if (stop) pend_d = 1'b1;
        if (word_fire && word_last && (pend_q || stop)) begin
          state_d = ST_FLUSH;
          pend_d  = 1'b0;
        end
      end
      ST_FLUSH: begin
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end
      default: begin
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      stopped_q <= (state_q == ST_FLUSH);
    end
  end

  assign run     = (state_q == ST_RUN);
  assign stopped = stopped_q;
endmodule

// File: rtl/pcm_half_packer.sv
module pcm_half_packer
  import pcm_pack_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic              smp_valid,
  input  logic [HALF_W-1:0] smp_left,
  input  logic [HALF_W-1:0] smp_right,
  input  logic              mono_q,
  input  logic [CW-1:0]     max_q,
  output logic              fire,
  output logic              last,
  output logic [WORD_W-1:0] word
);
  localparam int KW = CW + 1;

  logic [KW-1:0]     cnt_q, cnt_d, cnt_inc;
  logic [HALF_W-1:0] hold_q, hold_d;
  logic              hv_q, hv_d;
  logic              take;

  assign take = run && smp_valid;

  always_comb begin
    cnt_d   = cnt_q;
    hold_d  = hold_q;
    hv_d    = hv_q;
    fire    = 1'b0;
    last    = 1'b0;
    word    = '0;
    cnt_inc = mono_q ? KW'(1) : KW'(2);
    if (load) begin
      cnt_d = '0;
      hv_d  = 1'b0;
    end else if (take) begin
      cnt_d = cnt_q + cnt_inc;
      last  = (cnt_d >= KW'(max_q));
      if (!mono_q) begin
        fire = 1'b1;
        word = {smp_right, smp_left};
      end else if (hv_q) begin
        fire = 1'b1;
        word = {smp_left, hold_q};
        hv_d = 1'b0;
      end else if (last) begin
        fire = 1'b1;
        word = {{HALF_W{1'b0}}, smp_left};
      end else begin
        hold_d = smp_left;
        hv_d   = 1'b1;
      end
      if (last) begin
        cnt_d = '0;
        hv_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      hv_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hv_q  <= hv_d;
      if (take) hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/pcm_addr_gen.sv
module pcm_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fire,
  input  logic          last,
  input  logic [AW-1:0] base_q,
  output logic [AW-1:0] addr
);
  logic [CW-1:0] widx_q, widx_d;

  always_comb begin
    widx_d = widx_q;
    if (load)                widx_d = '0;
    else if (fire && last)   widx_d = '0;
    else if (fire)           widx_d = widx_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) widx_q <= '0;
    else        widx_q <= widx_d;
  end

  assign addr = base_q + (AW'(widx_q) << 2);
endmodule

// File: rtl/pcm_pack_writer.sv
module pcm_pack_writer
  import pcm_pack_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [15:0]   smp_left,
  input  logic [15:0]   smp_right,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] max_count,
  input  logic          mono,
  input  logic          start,
  input  logic          stop,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          stopped,
  output logic          buf_end
);
  logic              run, load, fire, last;
  logic [WORD_W-1:0] word;
  logic [AW-1:0]     addr;
  logic [AW-1:0]     base_q;
  logic [CW-1:0]     max_q;
  logic              mono_q;
  logic              we_q, end_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      max_q  <= '0;
      mono_q <= 1'b0;
    end else if (load) begin
      base_q <= base_addr;
      max_q  <= max_count;
      mono_q <= mono;
    end
  end

  pcm_run_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .word_fire (fire),
    .word_last (last),
    .run       (run),
    .load      (load),
    .stopped   (stopped)
  );

  pcm_half_packer #(.CW(CW)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .run       (run),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .mono_q    (mono_q),
    .max_q     (max_q),
    .fire      (fire),
    .last      (last),
    .word      (word)
  );

  pcm_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .fire   (fire),
    .last   (last),
    .base_q (base_q),
    .addr   (addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      end_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q  <= fire;
      end_q <= fire && last;
      if (fire) begin
        addr_q <= addr;
        data_q <= word;
      end
    end
  end

  assign mem_we    = we_q;
  assign buf_end   = end_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/pcm_pack_writer_chk.sv
module pcm_pack_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          buf_end,
  input logic          stopped,
  input logic [AW-1:0] base_q
);
  logic          prv_v, prv_end;
  logic [AW-1:0] prv_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_v    <= 1'b0;
      prv_end  <= 1'b0;
      prv_addr <= '0;
    end else if (stopped) begin
      prv_v <= 1'b0;
    end else if (mem_we) begin
      prv_v    <= 1'b1;
      prv_end  <= buf_end;
      prv_addr <= mem_addr;
    end
  end

  assert_end_with_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end |-> mem_we);

  assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && prv_v && prv_end) |-> (mem_addr == base_q));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && prv_v && !prv_end) |-> (mem_addr == prv_addr + AW'(4)));

  assert_stop_follows_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> $past(buf_end));

  assert_no_write_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !mem_we);

  assert_stop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !stopped);
endmodule

bind pcm_pack_writer pcm_pack_writer_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .buf_end  (buf_end),
  .stopped  (stopped),
  .base_q   (base_q)
);

// File: tb/pcm_pack_writer_tb.sv
module pcm_pack_writer_tb;
  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic        last;
    logic        stp;
    string       tag;
  } exp_t;

  logic        clk, rst_n;
  logic        smp_valid, mono, start, stop;
  logic [15:0] smp_left, smp_right;
  logic [31:0] base_addr;
  logic [15:0] max_count;
  logic        mem_we, stopped, buf_end;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0;
  int fails  = 0;
  int stops_seen = 0;
  bit done = 0;
  exp_t q[$];
  bit exp_stop_next = 0;

  // model state
  bit          m_run = 0, m_pend = 0, m_mono = 0, m_hv = 0;
  logic [31:0] m_base = 0;
  int          m_max = 0, m_cnt = 0, m_widx = 0;
  logic [15:0] m_hold = 0;

  pcm_pack_writer u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .base_addr(base_addr), .max_count(max_count),
    .mono(mono), .start(start), .stop(stop), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .stopped(stopped),
    .buf_end(buf_end)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] data, input bit last, input string tag);
    exp_t e;
    e.addr = m_base + 32'(m_widx * 4);
    e.data = data;
    e.last = last;
    e.stp  = last && m_pend;
    e.tag  = tag;
    q.push_back(e);
    if (last) begin
      m_widx = 0; m_cnt = 0; m_hv = 0;
      if (m_pend) begin m_run = 0; m_pend = 0; end
    end else m_widx++;
  endtask

  task automatic model_sample(input logic [15:0] l, input logic [15:0] r);
    bit last;
    if (!m_run) return;
    if (!m_mono) begin
      m_cnt += 2; last = (m_cnt >= m_max);
      push({r, l}, last, "R2");
    end else begin
      m_cnt += 1; last = (m_cnt >= m_max);
      if (m_hv) begin m_hv = 0; push({l, m_hold}, last, "R3"); end
      else if (last) push({16'h0, l}, last, "R4");
      else begin m_hold = l; m_hv = 1; end
    end
  endtask

  task automatic send(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    smp_valid = 1; smp_left = l; smp_right = r;
    model_sample(l, r);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic do_start(input logic [31:0] b, input int mx, input bit mo);
    @(negedge clk);
    start = 1; base_addr = b; max_count = 16'(mx); mono = mo;
    if (!m_run) begin
      m_run = 1; m_pend = 0; m_base = b; m_max = mx; m_mono = mo;
      m_cnt = 0; m_widx = 0; m_hv = 0;
    end
    @(negedge clk);
    start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop = 1;
    if (m_run) m_pend = 1;
    @(negedge clk);
    stop = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_stop_next) begin
        check(stopped === 1'b1, "R7 stopped after last write", 32'(stopped), 32'd1);
        check(mem_we === 1'b0, "R7 no write with stopped", 32'(mem_we), 32'd0);
      end else if (stopped) begin
        check(1'b0, "R7 unexpected stopped", 32'd1, 32'd0);
      end
      if (stopped) stops_seen++;
      exp_stop_next = 0;
      if (mem_we) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected write", mem_addr, 32'hx);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(mem_addr === e.addr, {"R5 address ", e.tag}, mem_addr, e.addr);
          check(mem_wdata === e.data, {e.tag, " data"}, mem_wdata, e.data);
          check(buf_end === e.last, "R6 buf_end", 32'(buf_end), 32'(e.last));
          exp_stop_next = e.stp;
        end
      end else if (buf_end) begin
        check(1'b0, "R6 buf_end without write", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      report();
    end
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_left = 0; smp_right = 0;
    base_addr = 0; max_count = 0; mono = 0; start = 0; stop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(mem_we === 1'b0, "R1 mem_we", 32'(mem_we), 32'd0);
    check(stopped === 1'b0, "R1 stopped", 32'(stopped), 32'd0);
    check(buf_end === 1'b0, "R1 buf_end", 32'(buf_end), 32'd0);
    send(16'h1111, 16'h2222);  // R9: no write while idle
    idle(2);

    // stereo, 4 samples -> 2 words per buffer (R2, R5, R6)
    do_start(32'h0000_1000, 4, 0);
    send(16'hA001, 16'hB001);
    send(16'hA002, 16'hB002);
    send(16'hA003, 16'hB003);   // wrapped to base
    do_stop();
    send(16'hA004, 16'hB004);   // buffer end -> stopped (R7)
    idle(3);
    send(16'hDEAD, 16'hBEEF);   // R9: ignored after stop
    idle(2);

    // mono, odd length 5 (R3, R4), start during run ignored (R8)
    do_start(32'h0000_2000, 5, 1);
    send(16'h0100, 16'hFFFF);
    send(16'h0101, 16'hFFFF);
    do_start(32'h0000_5000, 2, 0);
    send(16'h0102, 16'hFFFF);
    send(16'h0103, 16'hFFFF);
    send(16'h0104, 16'hFFFF);   // lone last sample, upper zero
    send(16'h0105, 16'hFFFF);
    do_stop();
    for (int i = 0; i < 4; i++) send(16'h0200 + 16'(i), 16'h0);
    idle(4);

    // stop while idle ignored (R9); stereo odd length 3 -> 2 words
    do_stop();
    idle(2);
    do_start(32'h0000_3000, 3, 0);
    send(16'hC001, 16'hD001);
    send(16'hC002, 16'hD002);   // buf_end, no stop
    send(16'hC003, 16'hD003);
    do_stop();
    send(16'hC004, 16'hD004);
    idle(5);

    check(q.size() == 0, "R5 all words written", 32'(q.size()), 32'd0);
    check(stops_seen == 3, "R7 stopped count", 32'(stops_seen), 32'd3);
    done = 1;
    report();
  end
endmodule